// File: doc/BRIEF.md
# Reset strap capture and boot configuration

This block is the first logic to run after a supply comes up. It holds the rest of the chip in reset for a fixed number of clocks after a power-good indication. It does the same for as long as an external reset request is low. Through the whole reset interval it keeps the output drivers of eight multifunction pins turned off, so that board-level pull resistors set their levels.

When reset ends, the block latches the eight pin levels into a configuration byte. The three low bits choose the serial-port protocol and give the low bits of the two-wire device address. The five high bits either select default register values or carry a condition code to an EEPROM loader, which answers with a done pulse. A ready flag tells the rest of the chip when its configuration is settled.

A new external reset during a pending load cancels that load. The whole capture-and-decode sequence then runs again on the next release.

Top module: `strap_boot_ctrl`

## Requirements
- R1: When `pwr_good` rises, `dev_rst` stays high for two synchronizer clocks plus `PULSE_CYCLES` clocks, whatever `ext_rst_n` does. With the default of 8, `dev_rst` is high at 9 consecutive falling-edge samples after the rise. `dev_rst` is high whenever `pwr_good` is low.
- R2: While `dev_rst` is high, `strap_oe` is all zeros. Once reset is released, `strap_oe` follows `pin_oe_cfg`.
- R3: On the first clock after `dev_rst` falls, `cfg_val[n]` takes the level of `strap_in[n]` for each n in 0..7. `cfg_val` then keeps that value until the next release of reset.
- R4: If `cfg_val[2:0]` is 000, `use_i2c` is 0 (SPI) and `i2c_addr_lo` is 0. Otherwise `use_i2c` is 1 and `i2c_addr_lo` equals `cfg_val[2:0]`.
- R5: If `cfg_val[7:3]` is 00000, `ee_req` stays 0, and `regs_default` and `cfg_ready` are 1 from the capture clock onward.
- R6: If `cfg_val[7:3]` is non-zero, `ee_req` rises on the capture clock and `ee_cond` equals `cfg_val[7:3]`. `cfg_ready` stays 0 until the first clock on which `ee_done` is seen high. On that clock `ee_req` falls and `cfg_ready` rises.
- R7: Reset arriving while `ee_req` is high clears `ee_req` and `cfg_ready` on the next clock. The next release captures the pins afresh.
- R8: A low `ext_rst_n` forces `dev_rst` high without waiting for a clock. After `ext_rst_n` rises, `dev_rst` falls on the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply-good indication, asynchronous, low clears the block |
| ext_rst_n | input | 1 | External reset request, asynchronous, active low |
| strap_in | input | 8 | Levels present on the multifunction pins |
| pin_oe_cfg | input | 8 | Output enables requested for the pins after boot |
| ee_done | input | 1 | EEPROM loader finished the requested transfer |
| dev_rst | output | 1 | Reset to the rest of the chip, active high |
| strap_oe | output | 8 | Output-driver enables of the multifunction pins |
| cfg_val | output | 8 | Captured strap byte |
| use_i2c | output | 1 | 1 selects the two-wire protocol, 0 selects SPI |
| i2c_addr_lo | output | 3 | Low bits of the two-wire device address |
| ee_req | output | 1 | Load request to the EEPROM loader |
| ee_cond | output | 5 | Load condition code |
| regs_default | output | 1 | Control registers keep their default values |
| cfg_ready | output | 1 | Boot configuration settled |

## Verification
The assertions check on every cycle that:
- the pin drivers are off during reset;
- a reset drops any pending load request on the next clock;
- the captured byte never moves except on a release;
- a pending request always carries a non-zero condition;
- ready and request are never high together.

Only the bench scenarios can show the rest: the exact length of the power-up pulse, the two-clock release delay of the external pin, the decode of each strap pattern, and the recapture after an aborted load.

// File: rtl/strap_boot_ctrl.sv
module strap_boot_ctrl #(
  parameter int PULSE_CYCLES = 8,
  parameter int NPINS        = 8,
  parameter int ADDR_W       = 3
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              ext_rst_n,
  input  logic [NPINS-1:0]  strap_in,
  input  logic [NPINS-1:0]  pin_oe_cfg,
  input  logic              ee_done,
  output logic              dev_rst,
  output logic [NPINS-1:0]  strap_oe,
  output logic [NPINS-1:0]  cfg_val,
  output logic              use_i2c,
  output logic [ADDR_W-1:0] i2c_addr_lo,
  output logic              ee_req,
  output logic [NPINS-ADDR_W-1:0] ee_cond,
  output logic              regs_default,
  output logic              cfg_ready
);

  localparam int COND_W = NPINS - ADDR_W;
  localparam int CNT_W  = $clog2(PULSE_CYCLES + 1);

  logic [1:0]       pg_sync;
  logic [1:0]       ext_sync;
  logic [CNT_W-1:0] pulse_cnt;
  logic             rst_q;
  logic [NPINS-1:0] cfg_q;
  logic             req_q;
  logic             ready_q;
  logic             pg_s;

  assign pg_s = pg_sync[1];

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) pg_sync <= '0;
    else           pg_sync <= {pg_sync[0], 1'b1};

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) ext_sync <= 2'b11;
    else            ext_sync <= {ext_sync[0], 1'b0};

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good)                       pulse_cnt <= CNT_W'(PULSE_CYCLES);
    else if (pg_s && pulse_cnt != '0)    pulse_cnt <= pulse_cnt - 1'b1;

  assign dev_rst = !pg_s || (pulse_cnt != '0) || ext_sync[1] || !ext_rst_n;

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      rst_q   <= 1'b1;
      cfg_q   <= '0;
      req_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      rst_q <= dev_rst;
      if (dev_rst) begin
        req_q   <= 1'b0;
        ready_q <= 1'b0;
      end else if (rst_q) begin
        cfg_q   <= strap_in;
        req_q   <= |strap_in[NPINS-1:ADDR_W];
        ready_q <= ~|strap_in[NPINS-1:ADDR_W];
      end else if (req_q && ee_done) begin
        req_q   <= 1'b0;
        ready_q <= 1'b1;
      end
    end

  assign strap_oe     = dev_rst ? '0 : pin_oe_cfg;
  assign cfg_val      = cfg_q;
  assign use_i2c      = |cfg_q[ADDR_W-1:0];
  assign i2c_addr_lo  = cfg_q[ADDR_W-1:0];
  assign ee_req       = req_q;
  assign ee_cond      = cfg_q[NPINS-1:ADDR_W];
  assign regs_default = ready_q && ~|cfg_q[NPINS-1:ADDR_W];
  assign cfg_ready    = ready_q;

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(pg_s) |-> dev_rst); // R1
  AST_OE_QUIET_IN_RST: assert property (@(posedge clk) disable iff (!pwr_good)
    dev_rst |-> strap_oe == '0); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!pwr_good)
    !(rst_q && !dev_rst) |=> $stable(cfg_val)); // R3
  AST_READY_NOT_REQ: assert property (@(posedge clk) disable iff (!pwr_good)
    cfg_ready |-> !ee_req); // R5
  AST_REQ_HAS_COND: assert property (@(posedge clk) disable iff (!pwr_good)
    ee_req |-> ee_cond != '0); // R6
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!pwr_good)
    (ee_req && ee_done && !dev_rst) |=> (cfg_ready && !ee_req)); // R6
  AST_RST_ABORTS_REQ: assert property (@(posedge clk) disable iff (!pwr_good)
    dev_rst |=> (!ee_req && !cfg_ready)); // R7
  AST_EXT_HOLDS_RST: assert property (@(posedge clk) disable iff (!pwr_good)
    !ext_rst_n |-> dev_rst); // R8

endmodule

// File: tb/test_strap_boot_ctrl.sv
module test_strap_boot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 8;

  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic ext_rst_n = 1'b1;
  logic [7:0] strap_in = 8'h00;
  logic [7:0] pin_oe_cfg = 8'h00;
  logic ee_done = 1'b0;
  logic dev_rst, use_i2c, ee_req, regs_default, cfg_ready;
  logic [7:0] strap_oe, cfg_val;
  logic [2:0] i2c_addr_lo;
  logic [4:0] ee_cond;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_boot_ctrl #(.PULSE_CYCLES(PULSE)) i_strap_boot_ctrl (
    .clk(clk), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n), .strap_in(strap_in),
    .pin_oe_cfg(pin_oe_cfg), .ee_done(ee_done), .dev_rst(dev_rst), .strap_oe(strap_oe),
    .cfg_val(cfg_val), .use_i2c(use_i2c), .i2c_addr_lo(i2c_addr_lo), .ee_req(ee_req),
    .ee_cond(ee_cond), .regs_default(regs_default), .cfg_ready(cfg_ready));

  // strap, use_i2c, addr, req, cond
  localparam logic [17:0] VEC [8] = '{
    {8'h00, 1'b0, 3'd0, 1'b0, 5'd0},
    {8'h01, 1'b1, 3'd1, 1'b0, 5'd0},
    {8'h07, 1'b1, 3'd7, 1'b0, 5'd0},
    {8'h08, 1'b0, 3'd0, 1'b1, 5'd1},
    {8'hFF, 1'b1, 3'd7, 1'b1, 5'd31},
    {8'hA5, 1'b1, 3'd5, 1'b1, 5'd20},
    {8'hF8, 1'b0, 3'd0, 1'b1, 5'd31},
    {8'h03, 1'b1, 3'd3, 1'b0, 5'd0}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic boot(input logic [7:0] s);
    @(negedge clk);
    ext_rst_n = 1'b0;
    strap_in = s;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int hi_cnt;
    pin_oe_cfg = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset while power low", dev_rst, 1);
    check("R2 oe off in reset", strap_oe, 0);
    check("R5 ready low in reset", cfg_ready, 0);

    // R1: power-up pulse length
    pwr_good = 1'b1;
    hi_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (dev_rst) hi_cnt++;
      if (dev_rst && strap_oe != 0) check("R2 oe off during pulse", strap_oe, 0);
    end
    check("R1 pulse length", hi_cnt, PULSE + 1);
    check("R2 oe follows cfg after release", strap_oe, 8'hFF);
    check("R5 ready after default boot", cfg_ready, 1);
    check("R5 regs default", regs_default, 1);

    // Table of strap patterns
    for (int i = 0; i < 8; i++) begin
      logic [7:0] s;
      s = VEC[i][17:10];
      boot(s);
      check("R3 capture", cfg_val, s);
      check("R4 protocol", use_i2c, VEC[i][9]);
      check("R4 address", i2c_addr_lo, VEC[i][8:6]);
      check("R6 request", ee_req, VEC[i][5]);
      if (VEC[i][5]) begin
        check("R6 cond", ee_cond, VEC[i][4:0]);
        check("R6 not ready before done", cfg_ready, 0);
        check("R6 not default", regs_default, 0);
        ee_done = 1'b1;
        @(negedge clk);
        ee_done = 1'b0;
        check("R6 req drop on done", ee_req, 0);
        check("R6 ready on done", cfg_ready, 1);
      end else begin
        check("R5 ready no load", cfg_ready, 1);
        check("R5 default regs", regs_default, 1);
      end
    end

    // R3: later pin changes are ignored
    strap_in = 8'h5A;
    repeat (3) @(negedge clk);
    check("R3 hold after capture", cfg_val, 8'h03);
    check("R4 hold protocol", use_i2c, 1);

    // R8: external reset asynchronous assert, two-clock release
    pin_oe_cfg = 8'h3C;
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    check("R8 async assert", dev_rst, 1);
    check("R2 oe off on ext reset", strap_oe, 0);
    @(negedge clk);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check("R8 still in reset after one edge", dev_rst, 1);
    @(negedge clk);
    check("R8 released after two edges", dev_rst, 0);
    @(negedge clk);
    check("R3 recapture", cfg_val, 8'h5A);
    check("R2 oe after ext release", strap_oe, 8'h3C);

    // R7: abort a pending load
    boot(8'h10);
    check("R6 pending request", ee_req, 1);
    @(negedge clk);
    ext_rst_n = 1'b0;
    strap_in = 8'h02;
    @(negedge clk);
    check("R7 request aborted", ee_req, 0);
    check("R7 ready cleared", cfg_ready, 0);
    ee_done = 1'b1;
    @(negedge clk);
    ee_done = 1'b0;
    ext_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 fresh capture", cfg_val, 8'h02);
    check("R7 no stale request", ee_req, 0);
    check("R7 ready after recapture", cfg_ready, 1);
    check("R4 address after recapture", i2c_addr_lo, 3'd2);

    finish_run();
  end
endmodule